// File: doc/BRIEF.md
# Exception Vector Base Register with Upper-Bit Write Gate

This block is a 32-bit control register that holds the base address from which a processor forms its exception vectors. Software updates it through a write strobe with a 32-bit data word and reads it back through a combinational read port. The lowest eleven bits are not stored. They come from an input port that carries constant identification bits, such as a core number, and they are merged into the read value.

Bit 11 is a gate bit. While the gate bit held in the register is clear, a write may change only the middle field, bits 29:11, so the top of the base stays inside its reset region. This matches software written for a register that had no gate. Once a previous write has set the gate bit, a write may also change bits 31:30. A parameter decides whether the gate bit exists. Without it, the gate bit stays zero and the top two bits keep their reset value.

Top module: `exc_vector_base`

## Requirements
- R1: After reset the read value is 0x8000_0000 with bits 10:0 taken from `low_const_i`.
- R2: Read bits 10:0 always equal `low_const_i`, and no write ever changes them, whatever the write data holds in those bits.
- R3: When the stored bit 11 is 0, a write loads bits 29:11 from the write data and leaves bits 31:30 at their stored values.
- R4: When the stored bit 11 is 1, a write loads all of bits 31:11 from the write data.
- R5: The gate is decided by bit 11 as stored before the write, not by bit 11 of the incoming data. Writing data with bits 31:30 and bit 11 both set into a register whose bit 11 is clear leaves bits 31:30 unchanged. A following write can then change them.
- R6: With `GATE_IMPL` = 0, bit 11 always reads 0 and bits 31:30 never change after reset.
- R7: A read in the same cycle as a write returns the old value. The new value appears in the cycle after the write.
- R8: Without a write, bits 31:11 hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| wr_data_i | input | 32 | Write data word |
| low_const_i | input | 11 | Constant bits shown at read bits 10:0 |
| rd_data_o | output | 32 | Current register value |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. One copy uses `GATE_IMPL` = 1 and reaches the full sequence: the gate opens from the stored bit, the top bits are reloaded, and the gate closes again through the same write. The other copy uses `GATE_IMPL` = 0 and shows that, with the same writes, the gate bit stays zero and the top two bits stay locked. Both copies keep the default 32-bit width and 11-bit constant field, so the bit positions named in the requirements apply directly.

// File: rtl/exc_vector_base_pkg.sv
`timescale 1ns/1ps
package exc_vector_base_pkg;

    // State of the upper-bit gate as seen by the write path
    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;

endpackage

// File: rtl/evb_gate_decode.sv
`timescale 1ns/1ps
module evb_gate_decode
    import exc_vector_base_pkg::*;
#(
    parameter bit GATE_IMPL = 1'b1
) (
    input  logic  stored_wg_i,
    output gate_e gate_o,
    output logic  wg_writable_o
);

    generate
        if (GATE_IMPL) begin : g_gate
            always_comb begin
                gate_o        = stored_wg_i ? GATE_OPEN : GATE_SHUT;
                wg_writable_o = 1'b1;
            end
        end else begin : g_no_gate
            logic unused_wg;
            always_comb begin
                unused_wg     = stored_wg_i;
                gate_o        = GATE_SHUT;
                wg_writable_o = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/evb_merge.sv
`timescale 1ns/1ps
module evb_merge
    import exc_vector_base_pkg::*;
#(
    parameter int UPPER_W = 21,
    parameter int PROT_W  = 2
) (
    input  logic [UPPER_W-1:0] cur_i,
    input  logic [UPPER_W-1:0] wr_i,
    input  gate_e              gate_i,
    input  logic               wg_writable_i,
    output logic [UPPER_W-1:0] nxt_o
);

    localparam int FREE_W = UPPER_W - PROT_W;

    always_comb begin
        nxt_o = cur_i;
        // middle field is always writable
        nxt_o[FREE_W-1:0] = wr_i[FREE_W-1:0];
        // protected top bits only pass when the stored gate is open
        if (gate_i == GATE_OPEN) begin
            nxt_o[UPPER_W-1:FREE_W] = wr_i[UPPER_W-1:FREE_W];
        end
        // gate bit is the lowest stored bit; forced to zero if absent
        if (!wg_writable_i) begin
            nxt_o[0] = 1'b0;
        end
    end

endmodule

// File: rtl/exc_vector_base.sv
`timescale 1ns/1ps
module exc_vector_base
    import exc_vector_base_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          CONST_W    = 11,
    parameter int          PROT_W     = 2,
    parameter bit          GATE_IMPL  = 1'b1,
    parameter logic [31:0] RESET_BASE = 32'h8000_0000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [XLEN-1:0]    wr_data_i,
    input  logic [CONST_W-1:0] low_const_i,
    output logic [XLEN-1:0]    rd_data_o
);

    localparam int UPPER_W = XLEN - CONST_W;
    localparam int FREE_W  = UPPER_W - PROT_W;
    localparam logic [UPPER_W-1:0] RESET_UPPER =
        GATE_IMPL ? RESET_BASE[XLEN-1:CONST_W]
                  : (RESET_BASE[XLEN-1:CONST_W] & ~{{(UPPER_W-1){1'b0}}, 1'b1});

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
    } state_t;

    state_t             st_d, st_q;
    gate_e              gate;
    logic               wg_writable;
    logic [UPPER_W-1:0] merged;

    evb_gate_decode #(
        .GATE_IMPL (GATE_IMPL)
    ) i_gate (
        .stored_wg_i   (st_q.upper[0]),
        .gate_o        (gate),
        .wg_writable_o (wg_writable)
    );

    evb_merge #(
        .UPPER_W (UPPER_W),
        .PROT_W  (PROT_W)
    ) i_merge (
        .cur_i         (st_q.upper),
        .wr_i          (wr_data_i[XLEN-1:CONST_W]),
        .gate_i        (gate),
        .wg_writable_i (wg_writable),
        .nxt_o         (merged)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.upper = merged;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.upper <= RESET_UPPER;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = {st_q.upper, low_const_i};

    // closed gate: top bits held, middle loaded (also covers R5)
    assert_closed_keeps_top_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !rd_data_o[CONST_W]) |=>
            rd_data_o[XLEN-1:XLEN-PROT_W] == $past(rd_data_o[XLEN-1:XLEN-PROT_W]));

    assert_closed_loads_mid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !rd_data_o[CONST_W]) |=>
            rd_data_o[XLEN-PROT_W-1:CONST_W+1] == $past(wr_data_i[XLEN-PROT_W-1:CONST_W+1]));

    assert_open_loads_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && rd_data_o[CONST_W]) |=>
            rd_data_o[XLEN-1:CONST_W] == $past(wr_data_i[XLEN-1:CONST_W]));

    assert_idle_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(rd_data_o[XLEN-1:CONST_W]));

    generate
        if (!GATE_IMPL) begin : g_chk_nogate
            assert_wg_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                !rd_data_o[CONST_W]);
            assert_top_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
                wr_en_i |=> $stable(rd_data_o[XLEN-1:XLEN-PROT_W]));
        end
    endgenerate

    initial begin
        assert (FREE_W > 1) else $error("field widths leave no middle field");
    end

endmodule

// File: tb/test_exc_vector_base.sv
`timescale 1ns/1ps
module test_exc_vector_base;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [10:0] low_const;
    logic [31:0] rd_g, rd_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expected stored bits 31:11 for gated and ungated copies
    logic [20:0] exp_g, exp_n;

    always #2.5 clk = ~clk;

    exc_vector_base #(.GATE_IMPL(1'b1)) i_exc_vector_base (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .low_const_i(low_const), .rd_data_o(rd_g));

    exc_vector_base #(.GATE_IMPL(1'b0)) i_exc_vector_base_nogate (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .low_const_i(low_const), .rd_data_o(rd_n));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [20:0] model(input logic [20:0] cur, input logic [31:0] d, input bit impl);
        logic [20:0] n;
        n = cur;
        n[18:0] = d[29:11];
        if (impl && cur[0]) n[20:19] = d[31:30];
        if (!impl) n[0] = 1'b0;
        return n;
    endfunction

    // one write; checks old value during the write cycle, new one after (R7)
    task automatic do_write(input logic [31:0] d, input string req);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        #1;
        check("R7 old value during write", rd_g, {exp_g, low_const});
        exp_g = model(exp_g, d, 1'b1);
        exp_n = model(exp_n, d, 1'b0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check(req, rd_g, {exp_g, low_const});
        check({req, " ungated R6"}, rd_n, {exp_n, low_const});
    endtask

    task automatic t_reset;
        check("R1 reset gated", rd_g, {32'h8000_0000} | {21'd0, low_const});
        check("R1 reset ungated", rd_n, {32'h8000_0000} | {21'd0, low_const});
    endtask

    task automatic t_closed_write;
        do_write(32'h4ABC_D7FF, "R3 closed write");
        check("R3 top bits kept", {30'd0, rd_g[31:30]}, 32'd2);
        check("R2 low bits from port", {21'd0, rd_g[10:0]}, {21'd0, low_const});
    endtask

    task automatic t_gate_stored;
        do_write(32'h4000_0800, "R5 gate set by this write");
        check("R5 top bits unchanged", {30'd0, rd_g[31:30]}, 32'd2);
        check("R5 gate now stored", {31'd0, rd_g[11]}, 32'd1);
        do_write(32'h4123_4800, "R5 R4 second write opens");
        check("R4 top bits loaded", {30'd0, rd_g[31:30]}, 32'd1);
        do_write(32'hC000_0000, "R4 open write clears gate");
        check("R4 top bits 11", {30'd0, rd_g[31:30]}, 32'd3);
        do_write(32'h0000_0000, "R3 closed again");
        check("R3 top bits still 11", {30'd0, rd_g[31:30]}, 32'd3);
    endtask

    task automatic t_low_const;
        @(negedge clk);
        low_const = 11'h2A5;
        #1;
        check("R2 low follows port", {21'd0, rd_g[10:0]}, 32'h2A5);
        do_write(32'hFFFF_F800 | 32'h0000_07FF, "R2 write ignores low data");
        check("R2 low after write", {21'd0, rd_g[10:0]}, 32'h2A5);
        check("R6 ungated wg zero", {31'd0, rd_n[11]}, 32'd0);
    endtask

    task automatic t_idle;
        repeat (4) @(negedge clk);
        #1;
        check("R8 idle gated", rd_g, {exp_g, low_const});
        check("R8 idle ungated", rd_n, {exp_n, low_const});
    endtask

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0;
        wr_data = 32'd0;
        low_const = 11'h5C3;
        exp_g = 21'h100000;
        exp_n = 21'h100000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset();
        t_closed_write();
        t_gate_stored();
        t_low_const();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule